// File: doc/BRIEF.md
# Configuration Address/Data Bridge

This block gives a host processor indirect access to the configuration space of downstream functions through two small registers. The first is a 32-bit address register. It holds an enable bit and the bus, device, function and register fields of the next access. The second is a data window. Accesses to the window are translated in the same cycle into one configuration request. The request carries bus, device, function, a byte-granular register offset, a forwarded byte count and write data.

The downstream side looks up the addressed function. It answers in the same cycle with a present flag, a power flag, a hot-added flag, a flag telling whether function 0 of that device is present, a bus-level flag that permits the 4 KiB extended register space, and read data. The bridge suppresses the request and returns all ones when access is not allowed. Access is not allowed when the enable bit is clear, the function is missing, the function is unpowered, or the function is a hot-added nonzero function without a function 0. The bridge also trims the byte count so that an access never runs past the end of the permitted space.

Top module: `cfgbr_top`

## Requirements
- R1: After reset the address register reads as 0x00000000, and data-window reads return 0xFFFFFFFF with no downstream request.
- R2: The address register changes only on a write with host_sel=0, host_off=0 and host_len=4. A write with any other offset or length leaves it unchanged.
- R3: A read with host_sel=0 returns the full 32-bit address register for every host_off and host_len.
- R4: While address bit 31 is 0, data-window reads return 0xFFFFFFFF and data-window writes raise no cfg_valid.
- R5: The request fields come from the address register: cfg_bus = bits 23:16, cfg_dev = bits 15:11, cfg_fn = bits 10:8. cfg_reg = bits 7:0 bitwise ORed with host_off. cfg_we follows host_we and cfg_wdata follows host_wdata.
- R6: cfg_bytes = min(host_len, limit - cfg_reg). The limit is 256, or 4096 when dn_ext_space=1.
- R7: When dn_present=0, reads return 0xFFFFFFFF and no request is raised.
- R8: When dn_powered=0, reads return all ones and no request is raised. The same holds when dn_hotadded=1, cfg_fn is nonzero and dn_fn0_present=0. A hot-added function 0, or a hot-added function whose function 0 is present, is served normally.
- R9: On an allowed read, host_rdata holds the low cfg_bytes bytes of dn_rdata, and all higher bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address register, 1 = data window |
| host_off | input | 2 | Byte offset within the selected register |
| host_len | input | 3 | Access length in bytes (1, 2 or 4) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| cfg_valid | output | 1 | Downstream request issued |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 12 | Byte-granular register offset |
| cfg_bytes | output | 3 | Forwarded byte count |
| cfg_wdata | output | 32 | Write data toward the function |
| dn_present | input | 1 | Addressed function exists |
| dn_powered | input | 1 | Addressed function is powered |
| dn_hotadded | input | 1 | Addressed function was hot-added |
| dn_fn0_present | input | 1 | Function 0 of the addressed device exists |
| dn_ext_space | input | 1 | Bus permits extended register space |
| dn_rdata | input | 32 | Read data from the function, right-justified |

## Verification
The bench places the address near the top of the 256-byte space with every window offset. A design that adds the offset instead of clamping, or that ignores the extended-space flag, forwards a count of 4 where 1 or 3 is due, or the reverse. A latch base with its low bits set separates OR from addition in the offset merge. Partial writes to the address register are used to catch a design that decodes only the length or only the offset. Each blocking condition is toggled on its own, including the hot-added function-0 case that must stay open, so that an inverted or missing term shows up as a stray request or a non-all-ones read. Short reads show whether the upper bytes are zeroed rather than passed through.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;
  localparam int DW         = 32;
  localparam int MAX_BYTES  = DW / 8;
  localparam int LEN_W      = $clog2(MAX_BYTES) + 1;
  localparam int BASE_SPACE = 256;
  localparam int EXT_SPACE  = 4096;
  localparam int OFF_W      = $clog2(BASE_SPACE);
  localparam int REG_W      = $clog2(EXT_SPACE);
  localparam int EN_BIT     = DW - 1;
  localparam int BUS_W      = 8;
  localparam int DEV_W      = 5;
  localparam int FN_W       = 3;
  localparam int ADDR_W     = BUS_W + DEV_W + FN_W + OFF_W;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [OFF_W-1:0] off;
  } cfg_addr_t;

  // Byte-granular offset: window offset bits are ORed into the latched base.
  function automatic logic [REG_W-1:0] merge_offset(logic [OFF_W-1:0] base,
                                                    logic [1:0] low);
    return REG_W'(base | OFF_W'(low));
  endfunction

  // Smaller of the requested length (capped) and the room left below the limit.
  function automatic logic [LEN_W-1:0] fwd_count(logic [LEN_W-1:0] len,
                                                 logic [REG_W-1:0] off,
                                                 logic ext);
    logic [REG_W:0] limit;
    logic [REG_W:0] room;
    logic [LEN_W-1:0] want;
    limit = ext ? (REG_W+1)'(EXT_SPACE) : (REG_W+1)'(BASE_SPACE);
    want  = (len > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len;
    if ({1'b0, off} >= limit) return '0;
    room = limit - {1'b0, off};
    if ((REG_W+1)'(want) > room) return LEN_W'(room);
    return want;
  endfunction

  // Keep the low n bytes, clear the rest.
  function automatic logic [DW-1:0] right_justify(logic [DW-1:0] d,
                                                  logic [LEN_W-1:0] n);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (LEN_W'(i) < n) r[i*8 +: 8] = d[i*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/cfgbr_latch.sv
module cfgbr_latch
  import cfgbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       off,
  input  logic [LEN_W-1:0] len,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    q,
  output logic             accept
);
  assign accept = wr && (off == 2'd0) && (len == LEN_W'(MAX_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (accept) q <= wdata;
  end
endmodule

// File: rtl/cfgbr_gate.sv
module cfgbr_gate
  import cfgbr_pkg::*;
(
  input  logic             enable,
  input  logic [FN_W-1:0]  fn,
  input  logic [REG_W-1:0] reg_off,
  input  logic [LEN_W-1:0] len,
  input  logic             ext,
  input  logic             present,
  input  logic             powered,
  input  logic             hotadded,
  input  logic             fn0_present,
  output logic             allow,
  output logic [LEN_W-1:0] bytes,
  output logic             orphan
);
  assign bytes  = fwd_count(len, reg_off, ext);
  assign orphan = hotadded && (fn != '0) && !fn0_present;
  assign allow  = enable && present && powered && !orphan && (bytes != '0);
endmodule

// File: rtl/cfgbr_rdmux.sv
module cfgbr_rdmux
  import cfgbr_pkg::*;
(
  input  logic             sel_window,
  input  logic             allow,
  input  logic [LEN_W-1:0] bytes,
  input  logic [DW-1:0]    latch_q,
  input  logic [DW-1:0]    dn_rdata,
  output logic [DW-1:0]    rdata
);
  always_comb begin
    if (!sel_window)  rdata = latch_q;
    else if (!allow)  rdata = '1;
    else              rdata = right_justify(dn_rdata, bytes);
  end
endmodule

// File: rtl/cfgbr_top.sv
module cfgbr_top
  import cfgbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic             host_sel,
  input  logic [1:0]       host_off,
  input  logic [LEN_W-1:0] host_len,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             cfg_valid,
  output logic             cfg_we,
  output logic [BUS_W-1:0] cfg_bus,
  output logic [DEV_W-1:0] cfg_dev,
  output logic [FN_W-1:0]  cfg_fn,
  output logic [REG_W-1:0] cfg_reg,
  output logic [LEN_W-1:0] cfg_bytes,
  output logic [DW-1:0]    cfg_wdata,
  input  logic             dn_present,
  input  logic             dn_powered,
  input  logic             dn_hotadded,
  input  logic             dn_fn0_present,
  input  logic             dn_ext_space,
  input  logic [DW-1:0]    dn_rdata
);
  logic [DW-1:0]    latch_q;
  logic             latch_accept;
  logic             latch_en;
  cfg_addr_t        addr;
  logic             window;
  logic [REG_W-1:0] reg_off;
  logic             allow;
  logic [LEN_W-1:0] bytes;
  logic             orphan;

  cfgbr_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (host_req && host_we && !host_sel),
    .off    (host_off),
    .len    (host_len),
    .wdata  (host_wdata),
    .q      (latch_q),
    .accept (latch_accept)
  );

  assign latch_en = latch_q[EN_BIT];
  assign addr     = cfg_addr_t'(latch_q[ADDR_W-1:0]);
  assign window   = host_req && host_sel;
  assign reg_off  = merge_offset(addr.off, host_off);

  cfgbr_gate u_gate (
    .enable      (latch_en),
    .fn          (addr.fn),
    .reg_off     (reg_off),
    .len         (host_len),
    .ext         (dn_ext_space),
    .present     (dn_present),
    .powered     (dn_powered),
    .hotadded    (dn_hotadded),
    .fn0_present (dn_fn0_present),
    .allow       (allow),
    .bytes       (bytes),
    .orphan      (orphan)
  );

  cfgbr_rdmux u_rdmux (
    .sel_window (host_sel),
    .allow      (allow),
    .bytes      (bytes),
    .latch_q    (latch_q),
    .dn_rdata   (dn_rdata),
    .rdata      (host_rdata)
  );

  assign cfg_valid = window && allow;
  assign cfg_we    = host_we;
  assign cfg_bus   = addr.bus;
  assign cfg_dev   = addr.dev;
  assign cfg_fn    = addr.fn;
  assign cfg_reg   = reg_off;
  assign cfg_bytes = bytes;
  assign cfg_wdata = host_wdata;
endmodule

// File: rtl/cfgbr_chk.sv
module cfgbr_chk
  import cfgbr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             host_we,
  input logic             host_sel,
  input logic [1:0]       host_off,
  input logic [LEN_W-1:0] host_len,
  input logic [DW-1:0]    host_rdata,
  input logic             cfg_valid,
  input logic [FN_W-1:0]  cfg_fn,
  input logic [LEN_W-1:0] cfg_bytes,
  input logic             dn_present,
  input logic             dn_powered,
  input logic             dn_hotadded,
  input logic             dn_fn0_present,
  input logic [DW-1:0]    latch_q
);
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && host_we && !host_sel && host_off == 2'd0 &&
      host_len == LEN_W'(MAX_BYTES)) |=> $stable(latch_q));

  a_r3_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_sel) |-> host_rdata == latch_q);

  a_r4_disabled_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_sel && !host_we && !latch_q[EN_BIT]) |-> host_rdata == '1);

  a_r4_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> latch_q[EN_BIT]);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_bytes != '0 && cfg_bytes <= host_len));

  a_r7_present: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> dn_present);

  a_r8_power_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (dn_powered && !(dn_hotadded && cfg_fn != '0 && !dn_fn0_present)));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !host_we && cfg_bytes == LEN_W'(1)) |-> host_rdata[DW-1:8] == '0);
endmodule

bind cfgbr_top cfgbr_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_req       (host_req),
  .host_we        (host_we),
  .host_sel       (host_sel),
  .host_off       (host_off),
  .host_len       (host_len),
  .host_rdata     (host_rdata),
  .cfg_valid      (cfg_valid),
  .cfg_fn         (cfg_fn),
  .cfg_bytes      (cfg_bytes),
  .dn_present     (dn_present),
  .dn_powered     (dn_powered),
  .dn_hotadded    (dn_hotadded),
  .dn_fn0_present (dn_fn0_present),
  .latch_q        (latch_q)
);

// File: tb/tb_cfgbr_top.sv
module tb_cfgbr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0, host_sel = 1'b0;
  logic [1:0]  host_off = '0;
  logic [2:0]  host_len = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cfg_valid, cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [11:0] cfg_reg;
  logic [2:0]  cfg_bytes;
  logic [31:0] cfg_wdata;
  logic        dn_present = 1'b1, dn_powered = 1'b1, dn_hotadded = 1'b0;
  logic        dn_fn0_present = 1'b1, dn_ext_space = 1'b0;
  logic [31:0] dn_rdata = 32'hA1B2C3D4;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfgbr_top dut (.*);

  typedef struct packed {
    logic [7:0]  lo;
    logic [1:0]  off;
    logic [2:0]  len;
    logic        ext;
    logic [11:0] exp_reg;
    logic [2:0]  exp_bytes;
    logic [31:0] exp_data;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h00, 2'd0, 3'd4, 1'b0, 12'h000, 3'd4, 32'hA1B2C3D4},
    '{8'h10, 2'd2, 3'd2, 1'b0, 12'h012, 3'd2, 32'h0000C3D4},
    '{8'h10, 2'd3, 3'd1, 1'b0, 12'h013, 3'd1, 32'h000000D4},
    '{8'h13, 2'd1, 3'd1, 1'b0, 12'h013, 3'd1, 32'h000000D4},
    '{8'hFC, 2'd0, 3'd4, 1'b0, 12'h0FC, 3'd4, 32'hA1B2C3D4},
    '{8'hFC, 2'd1, 3'd4, 1'b0, 12'h0FD, 3'd3, 32'h00B2C3D4},
    '{8'hFC, 2'd3, 3'd4, 1'b0, 12'h0FF, 3'd1, 32'h000000D4},
    '{8'hFC, 2'd3, 3'd4, 1'b1, 12'h0FF, 3'd4, 32'hA1B2C3D4},
    '{8'hFE, 2'd0, 3'd2, 1'b0, 12'h0FE, 3'd2, 32'h0000C3D4}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive an access after a falling edge; outputs are sampled 1 ns later.
  task automatic drive(logic sel, logic we, logic [1:0] off, logic [2:0] len,
                       logic [31:0] wd);
    @(negedge clk);
    host_req = 1'b1; host_sel = sel; host_we = we;
    host_off = off; host_len = len; host_wdata = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic set_latch(logic [31:0] v);
    drive(1'b0, 1'b1, 2'd0, 3'd4, v);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    drive(1'b0, 1'b0, 2'd0, 3'd4, '0);
    check("R1 latch after reset", host_rdata, 32'h0);
    drive(1'b1, 1'b0, 2'd0, 3'd4, '0);
    check("R1 window read after reset", host_rdata, 32'hFFFFFFFF);
    check("R1 no request after reset", {31'd0, cfg_valid}, 32'd0);
    idle();

    // R2: partial writes to the address register are ignored
    drive(1'b0, 1'b1, 2'd0, 3'd2, 32'h8000_1234); idle();
    drive(1'b0, 1'b1, 2'd1, 3'd4, 32'h8000_5678); idle();
    drive(1'b0, 1'b1, 2'd0, 3'd1, 32'h8000_9ABC); idle();
    drive(1'b0, 1'b0, 2'd0, 3'd4, '0);
    check("R2 partial writes ignored", host_rdata, 32'h0);
    idle();
    set_latch(32'h8005_1A40);
    drive(1'b0, 1'b0, 2'd2, 3'd1, '0);
    check("R2 full write taken / R3 read odd offset", host_rdata, 32'h8005_1A40);
    drive(1'b0, 1'b0, 2'd3, 3'd2, '0);
    check("R3 read other length", host_rdata, 32'h8005_1A40);
    idle();

    // R5: field decode and write forwarding (bus 05, dev 3, fn 2, reg 40)
    drive(1'b1, 1'b1, 2'd2, 3'd2, 32'hDEAD_BEEF);
    check("R5 request valid", {31'd0, cfg_valid}, 32'd1);
    check("R5 bus/dev/fn", {21'd0, cfg_bus, cfg_dev, cfg_fn}, {21'd0, 8'h05, 5'd3, 3'd2});
    check("R5 write fields", {20'd0, cfg_we, cfg_reg[10:0]}, {20'd0, 1'b1, 11'h042});
    check("R5 write data", cfg_wdata, 32'hDEAD_BEEF);
    idle();

    // R6 R9 R5: table of reads
    for (int i = 0; i < 9; i++) begin
      set_latch({1'b1, 7'd0, 8'h05, 5'd3, 3'd2, VECS[i].lo});
      dn_ext_space = VECS[i].ext;
      drive(1'b1, 1'b0, VECS[i].off, VECS[i].len, '0);
      check($sformatf("R5 reg offset vec %0d", i), {20'd0, cfg_reg}, {20'd0, VECS[i].exp_reg});
      check($sformatf("R6 byte count vec %0d", i), {29'd0, cfg_bytes}, {29'd0, VECS[i].exp_bytes});
      check($sformatf("R9 read data vec %0d", i), host_rdata, VECS[i].exp_data);
      check($sformatf("R6 valid vec %0d", i), {31'd0, cfg_valid}, 32'd1);
      idle();
    end
    dn_ext_space = 1'b0;

    // R4: enable clear
    set_latch(32'h0005_1A40);
    drive(1'b1, 1'b0, 2'd0, 3'd4, '0);
    check("R4 disabled read", host_rdata, 32'hFFFFFFFF);
    drive(1'b1, 1'b1, 2'd0, 3'd4, 32'h1111_2222);
    check("R4 disabled write no request", {31'd0, cfg_valid}, 32'd0);
    idle();

    // R7: absent function
    set_latch(32'h8005_1A40);
    dn_present = 1'b0;
    drive(1'b1, 1'b0, 2'd0, 3'd4, '0);
    check("R7 absent read", host_rdata, 32'hFFFFFFFF);
    drive(1'b1, 1'b1, 2'd0, 3'd4, 32'h1);
    check("R7 absent write no request", {31'd0, cfg_valid}, 32'd0);
    idle();
    dn_present = 1'b1;

    // R8: unpowered
    dn_powered = 1'b0;
    drive(1'b1, 1'b0, 2'd0, 3'd4, '0);
    check("R8 unpowered read", host_rdata, 32'hFFFFFFFF);
    drive(1'b1, 1'b1, 2'd0, 3'd4, 32'h1);
    check("R8 unpowered write no request", {31'd0, cfg_valid}, 32'd0);
    idle();
    dn_powered = 1'b1;

    // R8: hot-added fn 2 without function 0
    dn_hotadded = 1'b1; dn_fn0_present = 1'b0;
    drive(1'b1, 1'b0, 2'd0, 3'd4, '0);
    check("R8 orphan read", host_rdata, 32'hFFFFFFFF);
    check("R8 orphan no request", {31'd0, cfg_valid}, 32'd0);
    idle();
    // R8: hot-added fn 2 with function 0 present is served
    dn_fn0_present = 1'b1;
    drive(1'b1, 1'b0, 2'd0, 3'd4, '0);
    check("R8 hot-added with fn0 served", host_rdata, 32'hA1B2C3D4);
    idle();
    // R8: hot-added function 0 itself is served
    set_latch(32'h8005_1840);
    dn_fn0_present = 1'b0;
    drive(1'b1, 1'b0, 2'd0, 3'd4, '0);
    check("R8 hot-added fn0 served", {31'd0, cfg_valid}, 32'd1);
    idle();
    dn_hotadded = 1'b0; dn_fn0_present = 1'b1;

    // R1: reset clears the address register again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 1'b0, 2'd0, 3'd4, '0);
    check("R1 latch cleared by reset", host_rdata, 32'h0);
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule